// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block sits beside the register file of a UART that has receive and transmit FIFOs. It watches five interrupt conditions: receive line errors, received data ready, receive character timeout, transmit holding empty and modem status change. It keeps a pending flag for each condition that is event-driven, masks every condition with its own enable bit and ranks the enabled ones by a fixed priority. The result is a 4-bit identification code that the CPU reads to find the most urgent cause, together with one interrupt request line.

Each condition has its own way of being cleared. The line-error flag clears when the line status register is read. The timeout flag clears when the receive buffer is read. The modem flag clears when the modem status register is read. The data-ready condition is a level that follows the receive FIFO. The transmit-empty flag clears when the holding register is written, or when the identification register is read while that flag is the one being reported. The flag is armed on the rising edge of the empty condition, and again when its enable turns on while the holding register is already empty.

Top module: `uart_irq_id`

## Requirements
- R1: Out of reset all pending flags are clear, so `iid` = 0001 and `irq` = 0. Whenever no enabled condition is pending, `iid` = 0001 and `irq` = 0. In every other case `irq` = 1 and `iid` bit 0 = 0.
- R2: A pulse on `line_err` sets the line flag at that clock edge. While the flag and `ien[0]` are set, `iid` = 0110, and this beats every other condition. The flag is cleared by the edge on which `rd_lsr` is high.
- R3: The data-ready condition is a level with no storage: `rx_trig` in FIFO mode (`fifo_mode`=1) and `rx_avail` otherwise. When it is gated by `ien[1]` it gives `iid` = 0100.
- R4: In FIFO mode a pulse on `char_tout` sets the timeout flag. Gated by `ien[1]`, it gives `iid` = 1100 and ranks above data-ready. The flag is cleared by the edge on which `rd_rbr` is high.
- R5: A rising edge of `thr_empty` sets the transmit-empty flag. Gated by `ien[2]`, it gives `iid` = 0010 and ranks below the receive conditions.
- R6: An edge on which `wr_thr` is high clears the transmit-empty flag.
- R7: An edge on which `rd_iir` is high clears the transmit-empty flag only if `iid` was 0010 at that edge. Otherwise the flag is kept.
- R8: A change of `ien[2]` from 0 to 1 while `thr_empty` is high sets the transmit-empty flag.
- R9: A pulse on `msr_change` sets the modem flag. Gated by `ien[3]`, it gives `iid` = 0000, the lowest priority. The flag is cleared by the edge on which `rd_msr` is high.
- R10: The enables mask only what is reported. A flag whose enable is 0 is kept, and it is reported once the enable is set.
- R11: Outside FIFO mode, `char_tout` has no effect, `iid` bit 3 is 0, and any timeout flag is cleared at the next edge.
- R12: When a set and a clear of the same flag fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 = FIFO mode |
| ien | input | 4 | Enables: [0] line, [1] receive data/timeout, [2] transmit empty, [3] modem |
| line_err | input | 1 | Pulse: overrun, parity, framing or break detected |
| rx_avail | input | 1 | Level: receive data present (non-FIFO data-ready) |
| rx_trig | input | 1 | Level: receive FIFO at or above trigger (FIFO data-ready) |
| char_tout | input | 1 | Pulse: receive character timeout |
| thr_empty | input | 1 | Level: transmit holding register / FIFO empty |
| msr_change | input | 1 | Pulse: modem line change detected |
| rd_iir | input | 1 | CPU read of identification register |
| rd_lsr | input | 1 | CPU read of line status register |
| rd_rbr | input | 1 | CPU read of receive buffer |
| rd_msr | input | 1 | CPU read of modem status register |
| wr_thr | input | 1 | CPU write of transmit holding register |
| iid | output | 4 | Identification code |
| irq | output | 1 | Interrupt request |

## Verification
The pending flags are registered, so a set or clear stimulus shows up at `iid` and `irq` right after the next rising edge. Enables, `fifo_mode` and the data-ready levels act combinationally. The bench drives every stimulus at a falling edge, lets exactly one rising edge pass, and compares the outputs at the following falling edge, so each check sees the state one edge after its stimulus. The identification read is judged on the code present at the edge of the strobe. Its effect is checked one edge later, after the higher-priority source has been cleared.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IID_W   = 4;
    localparam int NUM_REQ = 5;

    // Request vector order is the priority order, index 0 highest.
    localparam int REQ_LINE = 0;
    localparam int REQ_TOUT = 1;
    localparam int REQ_RDA  = 2;
    localparam int REQ_THRE = 3;
    localparam int REQ_MSR  = 4;

    localparam logic [IID_W-1:0] IID_NONE = 4'b0001;
    localparam logic [IID_W-1:0] IID_LINE = 4'b0110;
    localparam logic [IID_W-1:0] IID_TOUT = 4'b1100;
    localparam logic [IID_W-1:0] IID_RDA  = 4'b0100;
    localparam logic [IID_W-1:0] IID_THRE = 4'b0010;
    localparam logic [IID_W-1:0] IID_MSR  = 4'b0000;

    typedef struct packed {
        logic line_p;
        logic tout_p;
        logic thre_p;
        logic msr_p;
        logic empty_prev;
        logic thre_en_prev;
    } irq_state_t;

    function automatic logic [IID_W-1:0] req_code(input int idx);
        case (idx)
            REQ_LINE: return IID_LINE;
            REQ_TOUT: return IID_TOUT;
            REQ_RDA:  return IID_RDA;
            REQ_THRE: return IID_THRE;
            default:  return IID_MSR;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode,
    input  logic thre_en,
    input  logic line_err,
    input  logic char_tout,
    input  logic thr_empty,
    input  logic msr_change,
    input  logic rd_lsr,
    input  logic rd_rbr,
    input  logic rd_msr,
    input  logic wr_thr,
    input  logic thre_ack,
    output logic line_pend,
    output logic tout_pend,
    output logic thre_pend,
    output logic msr_pend
);

    irq_state_t st_d, st_q;
    logic       thre_set;

    always_comb begin
        st_d = st_q;
        st_d.empty_prev   = thr_empty;
        st_d.thre_en_prev = thre_en;

        // Line status: read of the status register clears, a new error wins.
        if (rd_lsr)   st_d.line_p = 1'b0;
        if (line_err) st_d.line_p = 1'b1;

        // Timeout exists only in FIFO mode.
        if (rd_rbr || !fifo_mode)   st_d.tout_p = 1'b0;
        if (char_tout && fifo_mode) st_d.tout_p = 1'b1;

        // Transmit empty: edge of empty, or enable turning on while empty.
        thre_set = (thr_empty && !st_q.empty_prev) ||
                   (thr_empty && thre_en && !st_q.thre_en_prev);
        if (wr_thr || thre_ack) st_d.thre_p = 1'b0;
        if (thre_set)           st_d.thre_p = 1'b1;

        if (rd_msr)     st_d.msr_p = 1'b0;
        if (msr_change) st_d.msr_p = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{line_p: 1'b0, tout_p: 1'b0, thre_p: 1'b0, msr_p: 1'b0,
                      empty_prev: 1'b1, thre_en_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign line_pend = st_q.line_p;
    assign tout_pend = st_q.tout_p;
    assign thre_pend = st_q.thre_p;
    assign msr_pend  = st_q.msr_p;

    a_r2_lsr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !line_err) |=> !line_pend);
    a_r12_line_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |=> line_pend);
    a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thr && !thr_empty) |=> !thre_pend);
    a_r9_msr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msr && !msr_change) |=> !msr_pend);
    a_r11_no_tout_outside_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |=> !tout_pend);
    a_r4_rbr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rbr && !char_tout) |=> !tout_pend);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N_REQ = NUM_REQ
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic [N_REQ-1:0] req,
    output logic [IID_W-1:0] iid,
    output logic             irq
);

    logic [IID_W-1:0] code_tab [N_REQ];
    logic [IID_W-1:0] sel;

    for (genvar g = 0; g < N_REQ; g++) begin : g_code
        assign code_tab[g] = req_code(g);
    end

    always_comb begin
        sel = IID_NONE;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) sel = code_tab[i];
        end
        if (!fifo_mode) sel[IID_W-1] = 1'b0;
    end

    assign iid = sel;
    assign irq = |req;

    a_r1_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (iid == IID_NONE));
    a_r1_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !iid[0]);
    a_r2_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        req[REQ_LINE] |-> (iid == IID_LINE));
    a_r11_bit3_low: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> !iid[IID_W-1]);

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic [3:0]       ien,
    input  logic             line_err,
    input  logic             rx_avail,
    input  logic             rx_trig,
    input  logic             char_tout,
    input  logic             thr_empty,
    input  logic             msr_change,
    input  logic             rd_iir,
    input  logic             rd_lsr,
    input  logic             rd_rbr,
    input  logic             rd_msr,
    input  logic             wr_thr,
    output logic [IID_W-1:0] iid,
    output logic             irq
);

    logic               line_pend, tout_pend, thre_pend, msr_pend;
    logic               rda_lvl;
    logic               thre_ack;
    logic [NUM_REQ-1:0] req;

    // Clear-on-read of the identification register applies to the code seen now.
    assign thre_ack = rd_iir && (iid == IID_THRE);

    uart_irq_src i_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_mode),
        .thre_en    (ien[2]),
        .line_err   (line_err),
        .char_tout  (char_tout),
        .thr_empty  (thr_empty),
        .msr_change (msr_change),
        .rd_lsr     (rd_lsr),
        .rd_rbr     (rd_rbr),
        .rd_msr     (rd_msr),
        .wr_thr     (wr_thr),
        .thre_ack   (thre_ack),
        .line_pend  (line_pend),
        .tout_pend  (tout_pend),
        .thre_pend  (thre_pend),
        .msr_pend   (msr_pend)
    );

    assign rda_lvl = fifo_mode ? rx_trig : rx_avail;

    always_comb begin
        req           = '0;
        req[REQ_LINE] = line_pend && ien[0];
        req[REQ_TOUT] = tout_pend && ien[1];
        req[REQ_RDA]  = rda_lvl   && ien[1];
        req[REQ_THRE] = thre_pend && ien[2];
        req[REQ_MSR]  = msr_pend  && ien[3];
    end

    uart_irq_prio #(.N_REQ(NUM_REQ)) i_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (fifo_mode),
        .req       (req),
        .iid       (iid),
        .irq       (irq)
    );

    a_r7_ack_only_when_shown: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iir && (iid == IID_LINE) && !wr_thr && thre_pend) |=> thre_pend);
    a_r10_mask_keeps_msr: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_pend && !ien[3] && !rd_msr) |=> msr_pend);

endmodule

// File: tb/test_uart_irq_id.sv
module test_uart_irq_id;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_mode;
    logic [3:0] ien;
    logic       line_err, rx_avail, rx_trig, char_tout, thr_empty, msr_change;
    logic       rd_iir, rd_lsr, rd_rbr, rd_msr, wr_thr;
    logic [3:0] iid;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    uart_irq_id i_uart_irq_id (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .ien(ien),
        .line_err(line_err), .rx_avail(rx_avail), .rx_trig(rx_trig),
        .char_tout(char_tout), .thr_empty(thr_empty), .msr_change(msr_change),
        .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr),
        .wr_thr(wr_thr), .iid(iid), .irq(irq)
    );

    // m: [0] line, [1] data-ready, [2] timeout, [3] transmit empty, [4] modem
    function automatic logic [3:0] exp_code(input logic [4:0] m, input logic [3:0] e,
                                            input logic fm);
        if (m[0] && e[0])       return 4'b0110;
        if (m[2] && e[1] && fm) return 4'b1100;
        if (m[1] && e[1])       return 4'b0100;
        if (m[3] && e[2])       return 4'b0010;
        if (m[4] && e[3])       return 4'b0000;
        return 4'b0001;
    endfunction

    task automatic chk(input string req, input logic [3:0] exp);
        logic exp_irq;
        exp_irq = (exp != 4'b0001);
        checks++;
        if (iid !== exp || irq !== exp_irq) begin
            fails++;
            $display("FAIL %s: iid=%b irq=%b expected iid=%b irq=%b", req, iid, irq, exp, exp_irq);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        line_err = 0; char_tout = 0; msr_change = 0;
        rd_iir = 0; rd_lsr = 0; rd_rbr = 0; rd_msr = 0; wr_thr = 0;
    endtask

    task automatic clear_all();
        thr_empty = 0; rx_avail = 0; rx_trig = 0;
        rd_lsr = 1; rd_rbr = 1; rd_msr = 1; wr_thr = 1;
        tick();
    endtask

    task automatic load(input logic [4:0] m);
        line_err = m[0]; rx_trig = m[1]; rx_avail = m[1]; char_tout = m[2];
        thr_empty = m[3]; msr_change = m[4];
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; fifo_mode = 1; ien = 4'h0;
        line_err = 0; rx_avail = 0; rx_trig = 0; char_tout = 0; thr_empty = 0; msr_change = 0;
        rd_iir = 0; rd_lsr = 0; rd_rbr = 0; rd_msr = 0; wr_thr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk("R1 reset", 4'b0001);
        ien = 4'hF;
        clear_all();
        chk("R1 idle enabled", 4'b0001);

        // Priority sweep over every source combination (R2 R3 R4 R5 R9)
        for (int m = 0; m < 32; m++) begin
            clear_all();
            load(m[4:0]);
            chk("R2/R3/R4/R5/R9 priority sweep", exp_code(m[4:0], 4'hF, 1'b1));
        end

        // Enable sweep with every source present (R10)
        for (int e = 0; e < 16; e++) begin
            ien = e[3:0];
            clear_all();
            load(5'b11111);
            chk("R10 enable sweep", exp_code(5'b11111, e[3:0], 1'b1));
        end
        ien = 4'hF;

        // R2 clear by line status read
        clear_all(); load(5'b10001);
        chk("R2 line over modem", 4'b0110);
        rd_lsr = 1; tick();
        chk("R2 cleared by status read", 4'b0000);

        // R3 data-ready source selection
        clear_all();
        rx_avail = 1; rx_trig = 0; tick();
        chk("R3 fifo uses trigger", 4'b0001);
        fifo_mode = 0; tick();
        chk("R3 non-fifo uses avail", 4'b0100);
        rx_avail = 0; rx_trig = 1; tick();
        chk("R3 non-fifo ignores trigger", 4'b0001);
        fifo_mode = 1; rx_trig = 0; tick();

        // R4 timeout above data-ready, cleared by buffer read
        clear_all(); load(5'b00110);
        chk("R4 timeout code", 4'b1100);
        rd_rbr = 1; tick();
        chk("R4 buffer read clears timeout", 4'b0100);
        rx_trig = 0; rx_avail = 0; tick();
        chk("R3 level drop clears", 4'b0001);

        // R11 non-FIFO mode
        clear_all(); fifo_mode = 0;
        char_tout = 1; tick();
        chk("R11 timeout ignored", 4'b0001);
        fifo_mode = 1; load(5'b00100);
        chk("R11 timeout set in fifo", 4'b1100);
        fifo_mode = 0; tick();
        chk("R11 bit3 low", 4'b0001);
        fifo_mode = 1; tick();
        chk("R11 timeout dropped", 4'b0001);

        // R5/R6 transmit empty
        clear_all(); load(5'b01000);
        chk("R5 edge sets", 4'b0010);
        tick();
        chk("R5 level holds", 4'b0010);
        wr_thr = 1; tick();
        chk("R6 write clears", 4'b0001);

        // R7 identification read clears only the shown source
        clear_all(); load(5'b01001);
        chk("R7 line shown", 4'b0110);
        rd_iir = 1; tick();
        chk("R7 iid read not thre", 4'b0110);
        rd_lsr = 1; tick();
        chk("R7 thre kept", 4'b0010);
        rd_iir = 1; tick();
        chk("R7 iid read clears thre", 4'b0001);

        // R8 re-arm on enable
        clear_all();
        ien[2] = 0; tick();
        thr_empty = 1; tick();
        wr_thr = 1; tick();
        chk("R8 masked and cleared", 4'b0001);
        ien[2] = 1; tick();
        chk("R8 enable re-arms", 4'b0010);
        tick();
        chk("R8 no repeat set after clear", 4'b0010);

        // R9 modem
        clear_all(); load(5'b10000);
        chk("R9 modem code", 4'b0000);
        rd_msr = 1; tick();
        chk("R9 modem read clears", 4'b0001);

        // R10 masked flag retained
        clear_all(); ien[3] = 0;
        msr_change = 1; tick();
        chk("R10 masked modem", 4'b0001);
        tick();
        ien[3] = 1; tick();
        chk("R10 unmasked modem shows", 4'b0000);

        // R12 set wins
        clear_all();
        line_err = 1; rd_lsr = 1; tick();
        chk("R12 line set wins", 4'b0110);
        clear_all();
        msr_change = 1; rd_msr = 1; tick();
        chk("R12 modem set wins", 4'b0000);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule